// File: doc/BRIEF.md
# Eight-bit Timer with Compare-Clear Mode

This block is an up-counting timer with one compare channel. The counter advances on every clock cycle where the tick-enable input is high. Two counting behaviours are available. In free-running mode the counter wraps from its maximum value to zero. In compare-clear mode the counter returns to zero after it reaches the compare value, so the compare register sets the period.

A compare match can drive a waveform pin. A two-bit action field chooses what the pin does on a match: it can be left alone, toggled, driven low or driven high. The action field never affects counting. There are two sticky flags. One records a wrap past the counter's maximum. The other records a compare match. Hardware only sets each flag, and each has its own clear input that a host asserts, for example when it acknowledges an interrupt.

Software reaches the block through one write port. A two-bit selector picks the counter, the compare register or the control register as the target. All outputs come straight from registers.

Top module: `tmr8_cmpclr`

## Requirements
- R1: Synchronous active-high reset sets the following to zero: the counter, the compare register, the mode field, the action field, both flags and the waveform pin.
- R2: The mode field is bits [2:0] of a control write (`wr_sel`=2). Any mode value other than 2 gives free-running counting. On each cycle with `tick_en` high the counter goes up by one, and it wraps from 0xFF to 0x00. The counter holds its value on cycles with `tick_en` low.
- R3: The overflow flag is set at the same clock edge where an enabled tick moves the counter from 0xFF to 0x00. This applies in both modes.
- R4: Only `ovf_clr` clears the overflow flag. If a set and a clear arrive in the same cycle, the set wins.
- R5: In mode 2 the counter loads zero at the clock edge of an enabled tick where the count equals the compare value. With a compare value of 0xFF, this gives a period of 256 ticks and sets the overflow flag.
- R6: A counter write (`wr_sel`=0) loads `wr_data` at the next edge. It takes priority over the increment. In that cycle it also suppresses the compare match and the overflow.
- R7: The action field is bits [5:4] of a control write. At the edge of an enabled match tick the pin acts as follows: 00 leaves it unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R8: The value of the action field never changes the sequence of counter values.
- R9: The compare flag is set by every enabled match in either mode. `cmp_clr` clears it, and a set in the same cycle wins over the clear.
- R10: A compare write (`wr_sel`=1) is used for matching from the following cycle onward.
- R11: A write with `wr_sel`=3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Clear for the overflow flag |
| cmp_clr | input | 1 | Clear for the compare flag |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Waveform pin |

## Verification
A wrong count shows up on `cnt_q` at the very next edge. A wrong period in compare-clear mode shows as a missing or early return to zero within one period of ticks. A flag or pin error becomes visible one cycle after the faulty match or wrap. Because both flags are sticky, a spurious set stays on the port until it is cleared. The same applies to a lost clear. This is why the bench compares every output against its own model on every cycle and does not only look at chosen points.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 2;
  localparam logic [MODE_W-1:0] MODE_CTC = 3'd2;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_OFF = 2'd0,
    ACT_TGL = 2'd1,
    ACT_CLR = 2'd2,
    ACT_SET = 2'd3
  } act_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    act_e              act;
  } ctl_t;
endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_q,
  output ctl_t         ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q      <= '0;
      ctl_q.mode <= '0;
      ctl_q.act  <= ACT_OFF;
    end else if (wr_en) begin
      if (wr_sel == SEL_CMP) cmp_q <= wr_data;
      if (wr_sel == SEL_CTL) begin
        ctl_q.mode <= wr_data[MODE_W-1:0];
        ctl_q.act  <= act_e'(wr_data[5:4]);
      end
    end
  end
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cmp_val,
  input  logic         ctc_on,
  output logic [W-1:0] cnt_q,
  output logic         match_ev,
  output logic         wrap_ev
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic active;
  assign active   = tick_en && !ld_en;
  assign match_ev = active && (cnt_q == cmp_val);
  assign wrap_ev  = active && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (ld_en)              cnt_q <= ld_val;
    else if (ctc_on && match_ev) cnt_q <= '0;
    else if (tick_en)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_q[i] <= 1'b0;
      else if (set_ev[i]) flag_q[i] <= 1'b1;
      else if (clr_ev[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic match_ev,
  input  act_e act,
  output logic wave_q
);
  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else if (match_ev) begin
      unique case (act)
        ACT_TGL: wave_q <= ~wave_q;
        ACT_CLR: wave_q <= 1'b0;
        ACT_SET: wave_q <= 1'b1;
        default: wave_q <= wave_q;
      endcase
    end
  end
endmodule

// File: rtl/tmr8_cmpclr.sv
module tmr8_cmpclr
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_clr,
  input  logic         cmp_clr,
  output logic [W-1:0] cnt_q,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         wave_out
);
  localparam int FLAG_N = 2;
  localparam int F_OVF  = 0;
  localparam int F_CMP  = 1;

  ctl_t              ctl_q;
  logic [W-1:0]      cmp_q;
  logic [MODE_W-1:0] mode_q;
  act_e              act_q;
  logic              cnt_wr;
  logic              match_ev;
  logic              wrap_ev;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_clr;
  logic [FLAG_N-1:0] flag_q;

  assign mode_q = ctl_q.mode;
  assign act_q  = ctl_q.act;
  assign cnt_wr = wr_en && (wr_sel == SEL_CNT);

  tmr8_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cmp_q(cmp_q), .ctl_q(ctl_q)
  );

  tmr8_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld_en(cnt_wr),
    .ld_val(wr_data), .cmp_val(cmp_q), .ctc_on(mode_q == MODE_CTC),
    .cnt_q(cnt_q), .match_ev(match_ev), .wrap_ev(wrap_ev)
  );

  assign flag_set[F_OVF] = wrap_ev;
  assign flag_set[F_CMP] = match_ev;
  assign flag_clr[F_OVF] = ovf_clr;
  assign flag_clr[F_CMP] = cmp_clr;

  tmr8_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .set_ev(flag_set), .clr_ev(flag_clr), .flag_q(flag_q)
  );

  assign ovf_flag = flag_q[F_OVF];
  assign cmp_flag = flag_q[F_CMP];

  tmr8_wave u_wave (
    .clk(clk), .rst(rst), .match_ev(match_ev), .act(act_q), .wave_q(wave_out)
  );
endmodule

// File: rtl/tmr8_cmpclr_chk.sv
module tmr8_cmpclr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic         ovf_clr,
  input logic         cmp_clr,
  input logic [W-1:0] cnt_q,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         wave_out,
  input logic [2:0]   mode_q,
  input logic [1:0]   act_q,
  input logic [W-1:0] cmp_q
);
  localparam logic [W-1:0] CMAX = '1;
  logic cw, go, hit;
  assign cw  = wr_en && (wr_sel == 2'd0);
  assign go  = tick_en && !cw;
  assign hit = go && (cnt_q == cmp_q);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (cnt_q == '0) && !ovf_flag && !cmp_flag && !wave_out); // R1
  AST_FREE_INC: assert property (@(posedge clk) disable iff (rst) (go && mode_q != 3'd2) |=> cnt_q == W'($past(cnt_q) + 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!tick_en && !cw) |=> $stable(cnt_q)); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst) (go && cnt_q == CMAX) |=> ovf_flag && cnt_q == '0); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (ovf_flag && !ovf_clr) |=> ovf_flag); // R4
  AST_CTC_ZERO: assert property (@(posedge clk) disable iff (rst) (hit && mode_q == 3'd2) |=> cnt_q == '0); // R5
  AST_LOAD: assert property (@(posedge clk) disable iff (rst) cw |=> cnt_q == $past(wr_data)); // R6
  AST_TOGGLE: assert property (@(posedge clk) disable iff (rst) (hit && act_q == 2'd1) |=> wave_out != $past(wave_out)); // R7
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst) !hit |=> $stable(wave_out)); // R7
  AST_CMP_SET: assert property (@(posedge clk) disable iff (rst) hit |=> cmp_flag); // R9
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (rst) (cmp_flag && !cmp_clr) |=> cmp_flag); // R9
  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_sel == 2'd1) |=> cmp_q == $past(wr_data)); // R10
  AST_SEL3_INERT: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_sel == 2'd3) |=> $stable(cmp_q) && $stable(mode_q) && $stable(act_q)); // R11
endmodule

bind tmr8_cmpclr tmr8_cmpclr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .cnt_q(cnt_q),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .wave_out(wave_out),
  .mode_q(mode_q), .act_q(act_q), .cmp_q(cmp_q)
);

// File: tb/tmr8_cmpclr_test.sv
`timescale 1ns/1ps
module tmr8_cmpclr_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, wr_en = 1'b0, ovf_clr = 1'b0, cmp_clr = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] cnt_q;
  logic       ovf_flag, cmp_flag, wave_out;

  int checks = 0, fails = 0;
  int m_cnt, m_cmp, m_mode, m_act, m_ovf, m_cf, m_wave;
  string req = "R1";
  bit done = 0;
  int trace_a[$];
  int trace_b[$];

  always #4 clk = ~clk;

  tmr8_cmpclr uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .cnt_q(cnt_q),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit cw, hit, wrap;
    int n_cnt;
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_mode = 0; m_act = 0; m_ovf = 0; m_cf = 0; m_wave = 0;
      return;
    end
    cw   = wr_en && wr_sel == 2'd0;
    hit  = tick_en && !cw && m_cnt == m_cmp;
    wrap = tick_en && !cw && m_cnt == 255;
    if (cw) n_cnt = int'(wr_data);
    else if (tick_en) n_cnt = (m_mode == 2 && hit) ? 0 : (m_cnt + 1) % 256;
    else n_cnt = m_cnt;
    if (wrap) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    if (hit) m_cf = 1; else if (cmp_clr) m_cf = 0;
    if (hit) begin
      if (m_act == 1) m_wave = 1 - m_wave;
      else if (m_act == 2) m_wave = 0;
      else if (m_act == 3) m_wave = 1;
    end
    if (wr_en && wr_sel == 2'd1) m_cmp = int'(wr_data);
    if (wr_en && wr_sel == 2'd2) begin
      m_mode = int'(wr_data) % 8;
      m_act  = (int'(wr_data) / 16) % 4;
    end
    m_cnt = n_cnt;
  endtask

  task automatic cyc(bit t, bit we, int sel, int d, bit oc, bit cc);
    tick_en = t; wr_en = we; wr_sel = 2'(sel); wr_data = 8'(d);
    ovf_clr = oc; cmp_clr = cc;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(req, "cnt", int'(cnt_q), m_cnt);
    chk(req, "ovf", int'(ovf_flag), m_ovf);
    chk(req, "cmpflag", int'(cmp_flag), m_cf);
    chk(req, "wave", int'(wave_out), m_wave);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 3, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    req = "R1";
    rst = 1'b1;
    cyc(1, 1, 1, 77, 0, 0);
    cyc(1, 0, 3, 0, 0, 0);
    rst = 1'b0;
    cyc(0, 0, 3, 0, 0, 0);

    // R2: free-running with gaps in tick_en, crossing the wrap
    req = "R2";
    for (int i = 0; i < 300; i++) cyc(($urandom % 4) != 0, 0, 3, 0, 0, 0);
    cyc(0, 1, 2, 5, 0, 0);  // mode 5 also counts freely
    for (int i = 0; i < 280; i++) cyc(1, 0, 3, 0, 0, 0);
    cyc(0, 1, 2, 0, 0, 0);

    // R3: overflow flag raised on the wrap edge
    req = "R3";
    cyc(0, 0, 3, 0, 1, 0);
    cyc(0, 1, 0, 250, 0, 0);
    ticks(8);

    // R4: clear, and set beating clear in the same cycle
    req = "R4";
    cyc(0, 0, 3, 0, 1, 0);
    cyc(0, 1, 0, 254, 0, 0);
    cyc(1, 0, 3, 0, 0, 0);
    cyc(1, 0, 3, 0, 1, 0);   // count 255 wraps while clear asserted
    ticks(3);
    cyc(0, 0, 3, 0, 1, 0);

    // R5: compare-clear period with toggle action
    req = "R5";
    cyc(0, 1, 2, 8'h12, 0, 0);
    cyc(0, 1, 1, 5, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    ticks(40);

    // R10: new compare value used from next cycle
    req = "R10";
    cyc(1, 1, 1, 9, 0, 0);
    ticks(40);

    // R6: write beats increment and suppresses the match
    req = "R6";
    cyc(1, 1, 0, 9, 0, 0);
    cyc(1, 1, 0, 9, 0, 0);
    ticks(3);
    cyc(1, 1, 0, 200, 0, 1);  // jump above compare: runs to wrap
    ticks(70);

    // R5: compare 0xFF gives full period with overflow
    req = "R5";
    cyc(0, 0, 3, 0, 1, 1);
    cyc(0, 1, 1, 255, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    ticks(520);

    // R7: clear, set and disconnected actions
    req = "R7";
    cyc(0, 1, 1, 3, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 2, 8'h32, 0, 0); ticks(12);
    cyc(0, 1, 2, 8'h22, 0, 0); ticks(12);
    cyc(0, 1, 2, 8'h32, 0, 0); ticks(12);
    cyc(0, 1, 2, 8'h02, 0, 0); ticks(12);

    // R8: identical count traces under two different action values
    req = "R8";
    cyc(0, 1, 2, 8'h12, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin cyc(1, 0, 3, 0, 0, 0); trace_a.push_back(int'(cnt_q)); end
    cyc(0, 1, 2, 8'h32, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin cyc(1, 0, 3, 0, 0, 0); trace_b.push_back(int'(cnt_q)); end
    for (int i = 0; i < 20; i++) chk("R8", "trace", trace_b[i], trace_a[i]);

    // R9: compare flag set/clear, set wins
    req = "R9";
    cyc(0, 0, 3, 0, 0, 1);
    cyc(0, 1, 0, 2, 0, 0);
    cyc(1, 0, 3, 0, 0, 0);
    cyc(1, 0, 3, 0, 0, 1);   // match at 3 while clear asserted
    cyc(1, 0, 3, 0, 0, 1);
    ticks(5);

    // R11: selector 3 writes change nothing
    req = "R11";
    for (int i = 0; i < 6; i++) cyc(0, 1, 3, 8'hA7 + i, 0, 0);
    ticks(10);

    // R2: random stress across all inputs
    req = "R2";
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 3) != 0, ($urandom % 9) == 0, int'($urandom % 4), int'($urandom % 256),
          ($urandom % 7) == 0, ($urandom % 7) == 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule